// File: doc/BRIEF.md
# Page-Table DMA Address Translator

This block turns a device-side DMA address into a system physical address. The translation uses a table of entries, one per I/O page. Each entry holds a physical page address. The two lowest bits of the same word hold that page's access permission. The page size is set at runtime as a power-of-two shift. A requester offers an address measured from the start of the DMA window, together with the direction of the intended access. Two cycles later the block answers with four things: the translated page address, the I/O virtual page address, the in-page offset mask and the permission code.

Software or a loader fills the table through a simple one-entry-per-cycle write port. A runtime count says how many entries are live. Any index at or beyond that count misses. A miss, or an entry whose permission code is zero, grants no access; there is no separate error response. After reset the block sweeps every entry to zero before it accepts its first lookup, so every page faults until it is loaded. A one-cycle flag marks a lookup whose direction the page does not allow.

Top module: `tce_xlate`

## Requirements
- R1: A lookup is accepted on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly one cycle, two edges after acceptance. `req_ready` is low from the acceptance edge until the edge that produces the response, so at most one lookup is in flight.
- R2: The table index is `req_addr` shifted right by `cfg_shift`. The lookup is in range only when this index is strictly less than the live count.
- R3: A lookup that is not in range returns `rsp_perm` = 0, `rsp_addr` = 0, `rsp_iova` = 0, `rsp_mask` = all ones and `rsp_viol` = 0.
- R4: An in-range lookup returns `rsp_mask` = 2^shift − 1. It returns `rsp_addr` = entry AND NOT mask and `rsp_iova` = `req_addr` AND NOT mask, using the shift captured at acceptance.
- R5: An in-range lookup returns `rsp_perm` equal to entry bits [1:0], coded 0 = none, 1 = read only, 2 = write only, 3 = read and write.
- R6: `rsp_viol` is high with the response in two cases: an in-range read (`req_write` = 0) that hits code 2, and an in-range write that hits code 1. It is low in every other case.
- R7: Reset starts a sweep that writes zero to all DEPTH entries. `req_ready` stays low for exactly DEPTH cycles after reset is released, and every entry then reads as permission 0.
- R8: A write to the table while the reset sweep runs is ignored; the entry still reads zero afterwards.
- R9: A live count larger than DEPTH is treated as DEPTH.
- R10: A write on `wr_en` stores `wr_data` at `wr_idx`. A lookup accepted on a later edge sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clear sweep |
| cfg_shift | input | SHIFT_W | Page size as log2 of bytes |
| cfg_count | input | clog2(DEPTH)+1 | Number of live table entries |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | clog2(DEPTH) | Table write index |
| wr_data | input | ADDR_W | Entry value: page address with permission in bits [1:0] |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Lookup can be accepted |
| req_addr | input | ADDR_W | Window-relative DMA address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | ADDR_W | Translated physical page address |
| rsp_iova | output | ADDR_W | I/O virtual page address |
| rsp_mask | output | ADDR_W | In-page offset mask |
| rsp_perm | output | 2 | Permission code |
| rsp_viol | output | 1 | Access direction not allowed by the page |

## Verification
The bench builds the block with ADDR_W = 32, DEPTH = 16 and SHIFT_W = 5. With only 16 entries, the reset sweep takes a few cycles, and every entry can be loaded and looked up. Live counts above the depth (R9) can also be reached, because the count port can express values up to 31. The 32-bit address lets indices far past the table end be tried with small shifts. Several page shifts are tried, so the page address, virtual page address and mask can be checked at more than one page size.

// File: rtl/tce_pkg.sv
package tce_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RD   = 2'd1,
    PERM_WR   = 2'd2,
    PERM_RDWR = 2'd3
  } perm_e;

  function automatic logic dir_denied(input logic [1:0] code, input logic is_write);
    return (is_write && code == PERM_RD) || (!is_write && code == PERM_WR);
  endfunction
endpackage

// File: rtl/tce_ram.sv
module tce_ram #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tce_clear.sv
module tce_clear #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          clearing,
  output logic [AW-1:0] clr_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= 1'b1;
      clr_idx  <= '0;
    end else if (clearing) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == AW'(DEPTH - 1)) clearing <= 1'b0;
    end
  end

  a_r7_sweep_starts_at_zero: assert property (@(posedge clk) $fell(rst) |-> clearing && clr_idx == '0);
endmodule

// File: rtl/tce_issue.sv
module tce_issue #(
  parameter int ADDR_W  = 64,
  parameter int DEPTH   = 1024,
  parameter int SHIFT_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               block,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [CNT_W-1:0]   cfg_count,
  output logic               ram_re,
  output logic [IDX_W-1:0]   ram_raddr,
  output logic               s1_v,
  output logic [ADDR_W-1:0]  s1_addr,
  output logic               s1_write,
  output logic               s1_hit,
  output logic [SHIFT_W-1:0] s1_shift
);
  logic [ADDR_W-1:0] idx_full;
  logic [CNT_W-1:0]  live;
  logic              accept;

  assign req_ready = !block && !s1_v;
  assign accept    = req_valid && req_ready;
  assign idx_full  = req_addr >> cfg_shift;
  assign live      = (cfg_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cfg_count;
  assign ram_re    = accept;
  assign ram_raddr = idx_full[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_addr  <= '0;
      s1_write <= 1'b0;
      s1_hit   <= 1'b0;
      s1_shift <= '0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_addr  <= req_addr;
        s1_write <= req_write;
        s1_hit   <= idx_full < ADDR_W'(live);
        s1_shift <= cfg_shift;
      end
    end
  end

  a_r1_single_inflight: assert property (@(posedge clk) disable iff (rst) s1_v |-> !req_ready);
  a_r7_blocked_while_clearing: assert property (@(posedge clk) disable iff (rst) block |-> !req_ready);
endmodule

// File: rtl/tce_resolve.sv
module tce_resolve #(
  parameter int ADDR_W  = 64,
  parameter int SHIFT_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s1_v,
  input  logic [ADDR_W-1:0]  s1_addr,
  input  logic               s1_write,
  input  logic               s1_hit,
  input  logic [SHIFT_W-1:0] s1_shift,
  input  logic [ADDR_W-1:0]  entry,
  output logic               rsp_valid,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic [ADDR_W-1:0]  rsp_iova,
  output logic [ADDR_W-1:0]  rsp_mask,
  output logic [1:0]         rsp_perm,
  output logic               rsp_viol
);
  import tce_pkg::*;

  logic [ADDR_W-1:0] off_mask;
  assign off_mask = (ADDR_W'(1) << s1_shift) - ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_iova  <= '0;
      rsp_mask  <= '1;
      rsp_perm  <= PERM_NONE;
      rsp_viol  <= 1'b0;
    end else begin
      rsp_valid <= s1_v;
      if (s1_v) begin
        if (s1_hit) begin
          rsp_addr <= entry & ~off_mask;
          rsp_iova <= s1_addr & ~off_mask;
          rsp_mask <= off_mask;
          rsp_perm <= entry[1:0];
          rsp_viol <= dir_denied(entry[1:0], s1_write);
        end else begin
          rsp_addr <= '0;
          rsp_iova <= '0;
          rsp_mask <= '1;
          rsp_perm <= PERM_NONE;
          rsp_viol <= 1'b0;
        end
      end else begin
        rsp_viol <= 1'b0;
      end
    end
  end

  a_r3_miss_gives_nothing: assert property (@(posedge clk) disable iff (rst)
    s1_v && !s1_hit |=> rsp_perm == PERM_NONE && rsp_mask == '1 && rsp_addr == '0 && !rsp_viol);
  a_r6_viol_only_one_way: assert property (@(posedge clk) disable iff (rst)
    rsp_viol |-> rsp_valid && (rsp_perm == PERM_RD || rsp_perm == PERM_WR));
  a_r1_rsp_single_pulse: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/tce_xlate.sv
module tce_xlate #(
  parameter int ADDR_W  = 64,
  parameter int DEPTH   = 1024,
  parameter int SHIFT_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [CNT_W-1:0]   cfg_count,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ADDR_W-1:0]  wr_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  output logic               rsp_valid,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic [ADDR_W-1:0]  rsp_iova,
  output logic [ADDR_W-1:0]  rsp_mask,
  output logic [1:0]         rsp_perm,
  output logic               rsp_viol
);
  logic              clearing;
  logic [IDX_W-1:0]  clr_idx;
  logic              ram_we, ram_re;
  logic [IDX_W-1:0]  ram_waddr, ram_raddr;
  logic [ADDR_W-1:0] ram_wdata, ram_rdata;
  logic              s1_v, s1_write, s1_hit;
  logic [ADDR_W-1:0] s1_addr;
  logic [SHIFT_W-1:0] s1_shift;

  // the sweep owns the write port; external writes are dropped meanwhile
  assign ram_we    = clearing || wr_en;
  assign ram_waddr = clearing ? clr_idx : wr_idx;
  assign ram_wdata = clearing ? '0 : wr_data;

  tce_clear #(.DEPTH(DEPTH)) u_clear (
    .clk(clk), .rst(rst), .clearing(clearing), .clr_idx(clr_idx)
  );

  tce_ram #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  tce_issue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SHIFT_W(SHIFT_W)) u_issue (
    .clk(clk), .rst(rst), .block(clearing),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .cfg_shift(cfg_shift), .cfg_count(cfg_count),
    .ram_re(ram_re), .ram_raddr(ram_raddr),
    .s1_v(s1_v), .s1_addr(s1_addr), .s1_write(s1_write), .s1_hit(s1_hit), .s1_shift(s1_shift)
  );

  tce_resolve #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_resolve (
    .clk(clk), .rst(rst),
    .s1_v(s1_v), .s1_addr(s1_addr), .s1_write(s1_write), .s1_hit(s1_hit), .s1_shift(s1_shift),
    .entry(ram_rdata),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_iova(rsp_iova), .rsp_mask(rsp_mask),
    .rsp_perm(rsp_perm), .rsp_viol(rsp_viol)
  );

  a_r8_sweep_writes_zero: assert property (@(posedge clk) disable iff (rst)
    clearing |-> ram_we && ram_wdata == '0);
  a_r1_accept_blocks_next: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);
endmodule

// File: tb/sim_tce_xlate.sv
module sim_tce_xlate;
  localparam int AW = 32;
  localparam int DP = 16;
  localparam int SW = 5;
  localparam int IW = $clog2(DP);
  localparam int CW = IW + 1;

  logic clk = 0, rst = 1;
  logic [SW-1:0] cfg_shift = 5'd12;
  logic [CW-1:0] cfg_count = '0;
  logic wr_en = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [AW-1:0] wr_data = '0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_viol;
  logic [AW-1:0] rsp_addr, rsp_iova, rsp_mask;
  logic [1:0] rsp_perm;

  tce_xlate #(.ADDR_W(AW), .DEPTH(DP), .SHIFT_W(SW)) u0 (
    .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_count(cfg_count),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_iova(rsp_iova), .rsp_mask(rsp_mask),
    .rsp_perm(rsp_perm), .rsp_viol(rsp_viol)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [AW-1:0] model [DP];
  bit acc_d1 = 0, acc_d2 = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // response timing model: pulse two edges after each acceptance
  always @(posedge clk) begin
    acc_d2 <= acc_d1;
    acc_d1 <= !rst && req_valid && req_ready;
  end

  always @(negedge clk) begin
    if (!rst) chk(rsp_valid === acc_d2, "R1", "rsp_valid timing", longint'(rsp_valid), longint'(acc_d2));
  end

  task automatic put(input int idx, input logic [AW-1:0] val);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(idx); wr_data = val;
    @(posedge clk);
    model[idx] = val;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input logic [AW-1:0] a, input bit w, input string req);
    logic [AW-1:0] idx, msk, e, xa, xi, xm;
    logic [1:0] xp;
    bit hit, xv;
    int live;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w;
    @(posedge clk);
    idx = a >> cfg_shift;
    live = (int'(cfg_count) > DP) ? DP : int'(cfg_count);
    hit = idx < AW'(live);
    msk = (AW'(1) << cfg_shift) - AW'(1);
    if (hit) begin
      e = model[idx[IW-1:0]];
      xa = e & ~msk; xi = a & ~msk; xm = msk; xp = e[1:0];
      xv = (!w && xp == 2'd2) || (w && xp == 2'd1);
    end else begin
      xa = '0; xi = '0; xm = '1; xp = 2'd0; xv = 0;
    end
    @(negedge clk);
    req_valid = 0;
    chk(req_ready === 1'b0, "R1", "ready low in flight", longint'(req_ready), 0);
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R1", "rsp_valid", longint'(rsp_valid), 1);
    chk(rsp_addr === xa, req, "rsp_addr", longint'(rsp_addr), longint'(xa));
    chk(rsp_iova === xi, req, "rsp_iova", longint'(rsp_iova), longint'(xi));
    chk(rsp_mask === xm, req, "rsp_mask", longint'(rsp_mask), longint'(xm));
    chk(rsp_perm === xp, req, "rsp_perm", longint'(rsp_perm), longint'(xp));
    chk(rsp_viol === xv, (xv || hit) ? "R6" : req, "rsp_viol", longint'(rsp_viol), longint'(xv));
  endtask

  task automatic do_reset(input bit poke);
    int n;
    rst = 1;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b0 && rsp_valid === 1'b0, "R7", "reset state",
        longint'({req_ready, rsp_valid}), 0);
    rst = 0;
    for (int i = 0; i < DP; i++) model[i] = '0;
    if (poke) begin wr_en = 1; wr_idx = IW'(2); wr_data = 32'h0000_5003; end
    n = 0;
    for (int i = 0; i < 4 * DP; i++) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (req_ready) break;
    end
    wr_en = 0;
    chk(n == DP, "R7", "sweep length", longint'(n), longint'(DP));
  endtask

  function automatic logic [AW-1:0] pat(input int i);
    return ((i * 32'h0913_5A37) ^ 32'h00A5_0F3C) & ~32'h3 | AW'(i % 4);
  endfunction

  initial begin
    for (int i = 0; i < DP; i++) model[i] = '0;
    do_reset(1);                       // R8: write attempted during the sweep
    cfg_shift = 5'd12; cfg_count = 5'd8;
    look(32'h0000_2010, 0, "R8");      // entry 2 must still be zero
    look(32'h0000_5ABC, 1, "R7");      // cleared entry faults
    for (int i = 0; i < DP; i++) put(i, pat(i));   // R10 loads
    look(32'h0000_0123, 0, "R4");
    look(32'h0000_1FFF, 0, "R5");
    look(32'h0000_1004, 1, "R6");      // write to read-only page
    look(32'h0000_2777, 0, "R6");      // read of write-only page
    look(32'h0000_2777, 1, "R5");
    look(32'h0000_3800, 1, "R5");
    look(32'h0000_7FFF, 0, "R2");      // last live index
    look(32'h0000_8000, 0, "R3");      // first index past count
    look(32'hFFFF_F000, 1, "R3");
    cfg_shift = 5'd8; cfg_count = 5'd16;
    look(32'h0000_0A5A, 0, "R4");
    look(32'h0000_0FFF, 1, "R2");
    look(32'h0000_1000, 0, "R3");
    cfg_count = 5'd20;                 // R9: above depth
    look(32'h0000_0F01, 0, "R9");
    look(32'h0000_1001, 0, "R9");
    cfg_shift = 5'd2; cfg_count = 5'd16;
    look(32'h0000_0026, 0, "R4");
    cfg_count = 5'd0;
    look(32'h0000_0000, 0, "R2");
    cfg_shift = 5'd12; cfg_count = 5'd16;
    put(9, 32'h1234_5002);             // R10 overwrite
    look(32'h0000_9ABC, 1, "R10");
    do_reset(0);
    look(32'h0000_9ABC, 0, "R7");
    look(32'h0000_3000, 1, "R7");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule